// File: doc/BRIEF.md
# Single-Owner Coherence Home Directory

This block is the home node for a two-state (Modified / Invalid) cache coherence scheme. For every line it tracks whether one core holds that line in the Modified state and, if so, which core it is. Caches send it exclusive-read requests (GETX) and writebacks. A DMA engine sends it reads and writes. The directory answers with data, forwards, writeback acknowledgements and negative acknowledgements, and invalidations to the current owner. It also drives a backing-memory port whose response latency is not fixed.

The directory takes one request at a time. It holds `reqReady` low from acceptance until the final output of that request, so a request that arrives while a memory fetch or an owner invalidation is pending waits at the input. Ownership moves to a new requester in the same cycle as the forward. Because of this, a writeback from a core that has just lost the line gets a NACK, and that core then supplies the line to the forwarded requester.

Top module: `dir_mi_home`

## Requirements
- R1: After reset every tracked line is unowned, `reqReady` is high, and `outValid`, `memReqValid` and `dmaDone` are low.
- R2: A GETX (reqKind 0) to an unowned line issues one memory read (`memWrite`=0). Once `memRspValid` arrives, it sends outKind 1 (DATA) with the read data to the requester, and the requester becomes the owner.
- R3: A GETX to an owned line sends outKind 0 (FWD) to the old owner, with `outFwdTo` naming the requester. It makes no memory access, and the requester is the owner from then on.
- R4: A writeback (reqKind 1) from the recorded owner writes `reqData` to memory. After the write response it sends outKind 2 (WBACK) to that core and leaves the line unowned.
- R5: A writeback from any other core gets outKind 3 (NACK), makes no memory access, and leaves the ownership unchanged.
- R6: A DMA access (reqKind 2 read, 3 write) to an owned line sends outKind 4 (INV) to the owner. It touches no memory and does not complete until `invAckValid`. It then writes the owner's returned data to memory and leaves the line unowned.
- R7: A DMA read completes with a one-cycle `dmaDone` carrying the latest line data. That is the owner's returned data when the line was owned, and the memory contents otherwise.
- R8: A DMA write leaves memory holding `reqData`. When the line was owned, the owner's data is written first and the DMA data second. When it was unowned, only the DMA data is written. Completion is flagged by `dmaDone`.
- R9: `reqReady` is low whenever a memory request is issued. At most one memory request is outstanding, so `memReqValid` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Directory idle, request taken this cycle |
| reqKind | input | 2 | 0 GETX, 1 writeback, 2 DMA read, 3 DMA write |
| reqCore | input | CORE_W | Requesting core |
| reqAddr | input | IDX_W | Line index |
| reqData | input | DATA_W | Writeback or DMA write data |
| outValid | output | 1 | Message to a core, one cycle |
| outKind | output | 3 | 0 FWD, 1 DATA, 2 WBACK, 3 NACK, 4 INV |
| outDest | output | CORE_W | Destination core |
| outFwdTo | output | CORE_W | Requester named in a forward |
| outAddr | output | IDX_W | Line index of the message |
| outData | output | DATA_W | Line data for DATA |
| invAckValid | input | 1 | Owner returns data after an invalidation |
| invAckData | input | DATA_W | Owner's line data |
| memReqValid | output | 1 | Memory command, one cycle |
| memWrite | output | 1 | 1 write, 0 read |
| memAddr | output | IDX_W | Memory line index |
| memWdata | output | DATA_W | Write data |
| memRspValid | input | 1 | Read data or write completion |
| memRdata | input | DATA_W | Read data |
| dmaDone | output | 1 | DMA completion, one cycle |
| dmaData | output | DATA_W | DMA read data |

## Verification
The bench builds the block with 8 lines, 4 cores and 32-bit data. A small line count makes random traffic hit owned lines often. That brings forwards, stale-owner NACKs, and DMA accesses that must invalidate an owner well within reach. Memory and owner replies come after a random delay of one to three cycles, so each wait state is exercised with varying lengths.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {REQ_GETX = 2'd0, REQ_WB = 2'd1, REQ_DMARD = 2'd2, REQ_DMAWR = 2'd3} reqKind_e;
  typedef enum logic [2:0] {MSG_FWD = 3'd0, MSG_DATA = 3'd1, MSG_WBACK = 3'd2, MSG_NACK = 3'd3, MSG_INV = 3'd4} msgKind_e;
  typedef struct packed {
    logic capture;     // take the request fields
    logic setOwner;    // record requester as owner of the current line
    logic clrOwner;    // mark current line unowned
    logic latchMem;    // hold memory read data
    logic latchInv;    // hold owner's returned data
    logic memSrcHeld;  // memory write data from held register
  } ctrlStrobes_t;
endpackage

// File: rtl/dir_table.sv
module dir_table import dir_pkg::*; #(
  parameter int LINES = 16,
  parameter int NUM_CORES = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int CORE_W = $clog2(NUM_CORES)
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      st,
  input  logic [1:0]        reqKind,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [IDX_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] memRdata,
  input  logic [DATA_W-1:0] invAckData,
  output reqKind_e          curKind,
  output logic [CORE_W-1:0] curCore,
  output logic [IDX_W-1:0]  curAddr,
  output logic [DATA_W-1:0] heldData,
  output logic [DATA_W-1:0] memWdata,
  output logic              lineOwned,
  output logic [CORE_W-1:0] lineOwner
);
  logic [DATA_W-1:0] curData;
  logic [LINES-1:0]  ownVec;
  logic [CORE_W-1:0] ownIds [LINES];

  for (genvar e = 0; e < LINES; e++) begin : g_entry
    logic              valid;
    logic [CORE_W-1:0] owner;
    logic              hit;
    assign hit = (curAddr == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (rst) begin
        valid <= 1'b0;
        owner <= '0;
      end else if (hit && st.setOwner) begin
        valid <= 1'b1;
        owner <= curCore;
      end else if (hit && st.clrOwner) begin
        valid <= 1'b0;
      end
    end
    assign ownVec[e] = valid;
    assign ownIds[e] = owner;
  end

  assign lineOwned = ownVec[curAddr];
  assign lineOwner = ownIds[curAddr];

  always_ff @(posedge clk) begin
    if (rst) begin
      curKind  <= REQ_GETX;
      curCore  <= '0;
      curAddr  <= '0;
      curData  <= '0;
      heldData <= '0;
    end else begin
      if (st.capture) begin
        curKind <= reqKind_e'(reqKind);
        curCore <= reqCore;
        curAddr <= reqAddr;
        curData <= reqData;
      end
      if (st.latchMem) heldData <= memRdata;
      else if (st.latchInv) heldData <= invAckData;
    end
  end

  assign memWdata = st.memSrcHeld ? heldData : curData;
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl import dir_pkg::*; #(
  parameter int NUM_CORES = 4,
  localparam int CORE_W = $clog2(NUM_CORES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  reqKind_e          curKind,
  input  logic [CORE_W-1:0] curCore,
  input  logic              lineOwned,
  input  logic [CORE_W-1:0] lineOwner,
  input  logic              memRspValid,
  input  logic              invAckValid,
  output logic              reqReady,
  output ctrlStrobes_t      st,
  output logic              outValid,
  output msgKind_e          outKind,
  output logic              destIsOwner,
  output logic              memReqValid,
  output logic              memWrite,
  output logic              dmaDone
);
  typedef enum logic [3:0] {
    S_IDLE, S_DECIDE, S_MEMRD, S_WBWAIT, S_INVWAIT, S_OWNWR,
    S_OWNWAIT, S_DMAWR, S_DMAWAIT, S_RESP
  } state_e;

  state_e state, nextState;
  logic   isOwner;
  assign isOwner = lineOwned && (lineOwner == curCore);

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState   = state;
    st          = '0;
    reqReady    = 1'b0;
    outValid    = 1'b0;
    outKind     = MSG_DATA;
    destIsOwner = 1'b0;
    memReqValid = 1'b0;
    memWrite    = 1'b0;
    dmaDone     = 1'b0;
    unique case (state)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          st.capture = 1'b1;
          nextState  = S_DECIDE;
        end
      end
      S_DECIDE: begin
        unique case (curKind)
          REQ_GETX: begin
            if (lineOwned) begin
              outValid    = 1'b1;
              outKind     = MSG_FWD;
              destIsOwner = 1'b1;
              st.setOwner = 1'b1;
              nextState   = S_IDLE;
            end else begin
              memReqValid = 1'b1;
              nextState   = S_MEMRD;
            end
          end
          REQ_WB: begin
            if (isOwner) begin
              memReqValid = 1'b1;
              memWrite    = 1'b1;
              nextState   = S_WBWAIT;
            end else begin
              outValid  = 1'b1;
              outKind   = MSG_NACK;
              nextState = S_IDLE;
            end
          end
          default: begin
            if (lineOwned) begin
              outValid    = 1'b1;
              outKind     = MSG_INV;
              destIsOwner = 1'b1;
              nextState   = S_INVWAIT;
            end else if (curKind == REQ_DMARD) begin
              memReqValid = 1'b1;
              nextState   = S_MEMRD;
            end else begin
              memReqValid = 1'b1;
              memWrite    = 1'b1;
              nextState   = S_DMAWAIT;
            end
          end
        endcase
      end
      S_MEMRD: if (memRspValid) begin
        st.latchMem = 1'b1;
        nextState   = S_RESP;
      end
      S_WBWAIT: if (memRspValid) nextState = S_RESP;
      S_INVWAIT: if (invAckValid) begin
        st.latchInv = 1'b1;
        st.clrOwner = 1'b1;
        nextState   = S_OWNWR;
      end
      S_OWNWR: begin
        memReqValid   = 1'b1;
        memWrite      = 1'b1;
        st.memSrcHeld = 1'b1;
        nextState     = S_OWNWAIT;
      end
      S_OWNWAIT: if (memRspValid) nextState = (curKind == REQ_DMAWR) ? S_DMAWR : S_RESP;
      S_DMAWR: begin
        memReqValid = 1'b1;
        memWrite    = 1'b1;
        nextState   = S_DMAWAIT;
      end
      S_DMAWAIT: if (memRspValid) nextState = S_RESP;
      S_RESP: begin
        nextState = S_IDLE;
        unique case (curKind)
          REQ_GETX: begin
            outValid    = 1'b1;
            outKind     = MSG_DATA;
            st.setOwner = 1'b1;
          end
          REQ_WB: begin
            outValid    = 1'b1;
            outKind     = MSG_WBACK;
            st.clrOwner = 1'b1;
          end
          default: dmaDone = 1'b1;
        endcase
      end
      default: nextState = S_IDLE;
    endcase
  end
endmodule

// File: rtl/dir_mi_home.sv
module dir_mi_home import dir_pkg::*; #(
  parameter int LINES = 16,
  parameter int NUM_CORES = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES),
  localparam int CORE_W = $clog2(NUM_CORES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [1:0]        reqKind,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [IDX_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              outValid,
  output logic [2:0]        outKind,
  output logic [CORE_W-1:0] outDest,
  output logic [CORE_W-1:0] outFwdTo,
  output logic [IDX_W-1:0]  outAddr,
  output logic [DATA_W-1:0] outData,
  input  logic              invAckValid,
  input  logic [DATA_W-1:0] invAckData,
  output logic              memReqValid,
  output logic              memWrite,
  output logic [IDX_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic              memRspValid,
  input  logic [DATA_W-1:0] memRdata,
  output logic              dmaDone,
  output logic [DATA_W-1:0] dmaData
);
  ctrlStrobes_t      st;
  reqKind_e          curKind;
  msgKind_e          msgKind;
  logic [CORE_W-1:0] curCore, lineOwner;
  logic [IDX_W-1:0]  curAddr;
  logic [DATA_W-1:0] heldData;
  logic              lineOwned, destIsOwner;

  dir_table #(.LINES(LINES), .NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) u_table (
    .clk(clk), .rst(rst), .st(st),
    .reqKind(reqKind), .reqCore(reqCore), .reqAddr(reqAddr), .reqData(reqData),
    .memRdata(memRdata), .invAckData(invAckData),
    .curKind(curKind), .curCore(curCore), .curAddr(curAddr),
    .heldData(heldData), .memWdata(memWdata),
    .lineOwned(lineOwned), .lineOwner(lineOwner)
  );

  dir_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk(clk), .rst(rst), .reqValid(reqValid),
    .curKind(curKind), .curCore(curCore),
    .lineOwned(lineOwned), .lineOwner(lineOwner),
    .memRspValid(memRspValid), .invAckValid(invAckValid),
    .reqReady(reqReady), .st(st), .outValid(outValid), .outKind(msgKind),
    .destIsOwner(destIsOwner), .memReqValid(memReqValid), .memWrite(memWrite),
    .dmaDone(dmaDone)
  );

  assign outKind  = msgKind;
  assign outDest  = destIsOwner ? lineOwner : curCore;
  assign outFwdTo = curCore;
  assign outAddr  = curAddr;
  assign outData  = heldData;
  assign memAddr  = curAddr;
  assign dmaData  = heldData;
endmodule

// File: rtl/dir_mi_checker.sv
module dir_mi_checker (
  input logic       clk,
  input logic       rst,
  input logic       reqValid,
  input logic       reqReady,
  input logic       outValid,
  input logic [2:0] outKind,
  input logic       memReqValid,
  input logic       memWrite,
  input logic       memRspValid,
  input logic       invAckValid,
  input logic       dmaDone
);
  logic gotRead, memTouched, invPend;

  always_ff @(posedge clk) begin
    if (rst) begin
      gotRead    <= 1'b0;
      memTouched <= 1'b0;
      invPend    <= 1'b0;
    end else begin
      if (reqValid && reqReady) begin
        gotRead    <= 1'b0;
        memTouched <= 1'b0;
      end else begin
        if (memRspValid && !memWrite) gotRead <= 1'b1;
        if (memReqValid) memTouched <= 1'b1;
      end
      if (outValid && outKind == 3'd4) invPend <= 1'b1;
      else if (invAckValid) invPend <= 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (reqReady && !outValid && !memReqValid && !dmaDone));
  assert_data_after_read_R2: assert property (@(posedge clk) disable iff (rst)
    (outValid && outKind == 3'd1) |-> gotRead);
  assert_fwd_no_memory_R3: assert property (@(posedge clk) disable iff (rst)
    (outValid && outKind == 3'd0) |-> (!memTouched && !memReqValid));
  assert_nack_no_memory_R5: assert property (@(posedge clk) disable iff (rst)
    (outValid && outKind == 3'd3) |-> (!memTouched && !memReqValid));
  assert_inv_waits_ack_R6: assert property (@(posedge clk) disable iff (rst)
    invPend |-> (!memReqValid && !dmaDone));
  assert_busy_on_memreq_R9: assert property (@(posedge clk) disable iff (rst)
    memReqValid |-> !reqReady);
  assert_single_memreq_R9: assert property (@(posedge clk) disable iff (rst)
    memReqValid |=> !memReqValid);
endmodule

bind dir_mi_home dir_mi_checker u_chk (
  .clk(clk), .rst(rst), .reqValid(reqValid), .reqReady(reqReady),
  .outValid(outValid), .outKind(outKind), .memReqValid(memReqValid),
  .memWrite(memWrite), .memRspValid(memRspValid), .invAckValid(invAckValid),
  .dmaDone(dmaDone)
);

// File: tb/tb_dir_mi_home.sv
module tb_dir_mi_home;
  localparam int CLK_PERIOD = 10;
  localparam int LINES = 8;
  localparam int NUM_CORES = 4;
  localparam int DATA_W = 32;
  localparam int IDX_W = $clog2(LINES);
  localparam int CORE_W = $clog2(NUM_CORES);

  logic clk = 1'b0, rst = 1'b1;
  logic reqValid = 1'b0, reqReady;
  logic [1:0] reqKind = '0;
  logic [CORE_W-1:0] reqCore = '0;
  logic [IDX_W-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqData = '0;
  logic outValid; logic [2:0] outKind;
  logic [CORE_W-1:0] outDest, outFwdTo;
  logic [IDX_W-1:0] outAddr; logic [DATA_W-1:0] outData;
  logic invAckValid = 1'b0; logic [DATA_W-1:0] invAckData = '0;
  logic memReqValid, memWrite; logic [IDX_W-1:0] memAddr; logic [DATA_W-1:0] memWdata;
  logic memRspValid = 1'b0; logic [DATA_W-1:0] memRdata = '0;
  logic dmaDone; logic [DATA_W-1:0] dmaData;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_mi_home #(.LINES(LINES), .NUM_CORES(NUM_CORES), .DATA_W(DATA_W)) dut (.*);

  int checks = 0, fails = 0;
  logic [DATA_W-1:0] memModel [LINES];
  logic [DATA_W-1:0] held [LINES];
  logic refV [LINES];
  logic [CORE_W-1:0] refO [LINES];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doTxn(input int kind, input int core, input int addr, input logic [DATA_W-1:0] data);
    int termKind = -1, termDest = 0, termFwd = 0, reads = 0, writes = 0;
    int memCnt = -1, invCnt = -1, invDest = -1, cyc = 0;
    logic [DATA_W-1:0] termData = '0, firstW = '0, lastW = '0, rdVal = '0;
    bit dmaSeen = 0;
    logic [DATA_W-1:0] dmaVal = '0;
    bit wasOwned = refV[addr];
    int oldOwner = refO[addr];
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1; reqKind = 2'(kind); reqCore = CORE_W'(core);
    reqAddr = IDX_W'(addr); reqData = data;
    @(negedge clk);
    reqValid = 1'b0;
    while (termKind < 0 && !dmaSeen && cyc < 200) begin
      memRspValid = 1'b0; invAckValid = 1'b0;
      if (memCnt > 0) memCnt--;
      if (memCnt == 0) begin memRspValid = 1'b1; memRdata = rdVal; memCnt = -1; end
      if (invCnt > 0) invCnt--;
      if (invCnt == 0) begin invAckValid = 1'b1; invAckData = held[addr]; invCnt = -1; end
      if (memReqValid) begin
        if (memWrite) begin
          writes++; if (writes == 1) firstW = memWdata; lastW = memWdata;
          memModel[memAddr] = memWdata;
        end else begin
          reads++; rdVal = memModel[memAddr];
        end
        memCnt = 1 + int'($urandom % 3);
      end
      if (outValid) begin
        if (outKind == 3'd4) begin invDest = int'(outDest); invCnt = 1 + int'($urandom % 3); end
        else begin termKind = int'(outKind); termDest = int'(outDest); termFwd = int'(outFwdTo); termData = outData; end
      end
      if (dmaDone) begin dmaSeen = 1; dmaVal = dmaData; end
      if (termKind < 0 && !dmaSeen) @(negedge clk);
      cyc++;
    end
    if (cyc >= 200) check("R9 transaction hung", 1, 0);
    memRspValid = 1'b0; invAckValid = 1'b0;
    case (kind)
      0: if (wasOwned) begin
           check("R3 FWD kind", termKind, 0); check("R3 FWD dest old owner", termDest, oldOwner);
           check("R3 FWD names requester", termFwd, core); check("R3 no memory access", reads + writes, 0);
           refO[addr] = CORE_W'(core); held[addr] = $urandom;
         end else begin
           check("R2 DATA kind", termKind, 1); check("R2 DATA dest", termDest, core);
           check("R2 one read", reads, 1); check("R2 data value", termData, memModel[addr]);
           refV[addr] = 1; refO[addr] = CORE_W'(core); held[addr] = $urandom;
         end
      1: if (wasOwned && oldOwner == core) begin
           check("R4 WBACK kind", termKind, 2); check("R4 WBACK dest", termDest, core);
           check("R4 memory updated", memModel[addr], data); check("R4 one write", writes, 1);
           refV[addr] = 0;
         end else begin
           check("R5 NACK kind", termKind, 3); check("R5 NACK dest", termDest, core);
           check("R5 no memory access", reads + writes, 0);
         end
      default: begin
        check("R7 R8 dmaDone seen", dmaSeen, 1);
        if (wasOwned) begin
          check("R6 INV to owner", invDest, oldOwner); check("R6 owner data first", firstW, held[addr]);
          refV[addr] = 0;
        end else check("R6 no INV when unowned", invDest, -1);
        if (kind == 2) begin
          check("R7 DMA read data", dmaVal, wasOwned ? held[addr] : memModel[addr]);
          check("R7 write count", writes, wasOwned ? 1 : 0);
        end else begin
          check("R8 memory holds DMA data", memModel[addr], data);
          check("R8 last write DMA data", lastW, data); check("R8 write count", writes, wasOwned ? 2 : 1);
        end
      end
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < LINES; i++) begin
      memModel[i] = 32'hA000_0000 + 32'(i); held[i] = '0; refV[i] = 0; refO[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reqReady after reset", reqReady, 1);
    check("R1 outValid low", outValid, 0);
    check("R1 memReqValid low", memReqValid, 0);
    check("R1 dmaDone low", dmaDone, 0);
    // directed corners
    doTxn(0, 1, 0, 0);                 // R2 first touch
    doTxn(0, 2, 0, 0);                 // R3 forward
    doTxn(1, 1, 0, 32'h1111_0000);     // R5 stale owner NACK
    doTxn(1, 2, 0, held[0]);           // R4 owner writeback
    doTxn(2, 0, 0, 0);                 // R7 unowned DMA read
    doTxn(0, 3, LINES-1, 0);           // R2 last line
    doTxn(3, 0, LINES-1, 32'hDEAD_BEEF); // R8 owned DMA write
    doTxn(0, 0, 3, 0);
    doTxn(2, 1, 3, 0);                 // R6 R7 owned DMA read
    doTxn(3, 1, 3, 32'h5A5A_5A5A);     // R8 unowned DMA write
    for (int n = 0; n < 300; n++) begin
      int k = int'($urandom % 4);
      int c = int'($urandom % NUM_CORES);
      int a = int'($urandom % LINES);
      logic [DATA_W-1:0] d = $urandom;
      if (k == 1 && refV[a] && ($urandom % 2 == 0)) begin c = int'(refO[a]); d = held[a]; end
      doTxn(k, c, a, d);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule